// File: doc/BRIEF.md
# Dual-Channel Serial Converter Input Register

This block is the digital front end of a two-channel 12-bit converter. A host shifts 14-bit frames in over a serial line, framed by an active-low chip select, and strobes an active-low load input to move the received code into one or both channel output registers. The two held 12-bit codes drive the analog ladders, which lie outside this block.

All four serial pins are sampled in the system clock domain. A two-flop synchronizer brings them in. A rising-edge detector on the synchronized serial clock yields a one-cycle shift enable. While the load strobe is low, the channel registers follow the shift register on every system clock cycle, so they behave like level-transparent latches. A 2-bit address at the head of the frame selects channel A, channel B or both.

Top module: `dual_dac_frontend`

## Requirements
- R1: A frame is shifted most significant bit first: two address bits (upper bit first, then lower), then the 12-bit code from bit 11 down to bit 0. When more than 14 bits are clocked in, the last 14 received form the frame.
- R2: A bit is captured only on a rising edge of the serial clock while chip select is low. Edges that arrive while chip select is high leave the shift register unchanged.
- R3: While the load strobe is high, both channel outputs hold their values, whatever the serial pins do.
- R4: While the load strobe is low and the upper address bit is 0 (lower bit ignored), the 12-bit code is written into both channel A and channel B.
- R5: While the load strobe is low and the address is upper=1, lower=0, only channel A is written; channel B holds.
- R6: While the load strobe is low and the address is upper=1, lower=1, only channel B is written; channel A holds.
- R7: While the load strobe is low, the channel registers stay transparent, so every bit shifted in shows up on the selected outputs. The address and code used are those in the shift register at that moment.
- R8: A synchronous active-high reset clears the shift register and both channel outputs to 0x000.
- R9: The code is straight binary and passes to the outputs unchanged, so 0x000, 0x800 and 0xFFF come out as 0x000, 0x800 and 0xFFF.
- R10: The shift enable is a single system clock cycle wide for each rising serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| sdata_i | input | 1 | Serial data, sampled on rising serial clock |
| csn_i | input | 1 | Active-low chip select |
| loadn_i | input | 1 | Active-low load strobe, transparent while low |
| code_a_o | output | 12 | Held code of channel A |
| code_b_o | output | 12 | Held code of channel B |

## Verification
Random frames use all four address values and random codes. Some carry extra leading bits, which tell whether the frame keeps the last 14 bits or the first. Others have bursts clocked while chip select is high, which tell whether deselected edges are really ignored. Directed frames with 0x000, 0x800 and 0xFFF check that codes pass unchanged. A bit-by-bit shift with the load strobe held low tells true transparency apart from a strobe-edge transfer, because the address itself slides through the register. A reset issued mid-run, followed by a load, shows whether the shift register was cleared as well as the outputs.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  localparam int ADDR_W = 2;
  localparam int NCH    = 2;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;

  // Channel write mask from the frame address: upper bit 0 selects both,
  // 10 selects channel A, 11 selects channel B.
  function automatic logic [NCH-1:0] dst_mask(input logic [ADDR_W-1:0] addr);
    logic [NCH-1:0] m;
    if (!addr[1]) m = 2'b11;
    else if (!addr[0]) m = 2'b01;
    else m = 2'b10;
    return m;
  endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift #(
  parameter int CODE_W = 12,
  parameter int ADDR_W = 2,
  localparam int FRAME_W = CODE_W + ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               csn_s,
  input  logic               sdata_s,
  output logic               shift_en,
  output logic [FRAME_W-1:0] frame_o
);

  logic sclk_prev;
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_s;
  end

  assign shift_en = sclk_s & ~sclk_prev;

  always_ff @(posedge clk) begin
    if (rst)                    frame_q <= '0;
    else if (shift_en && !csn_s) frame_q <= {frame_q[FRAME_W-2:0], sdata_s};
  end

  assign frame_o = frame_q;

  // R10
  shift_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> !shift_en);

  // R2
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> $stable(frame_q));

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !csn_s) |=>
      (frame_q[0] == $past(sdata_s)) &&
      (frame_q[FRAME_W-1:1] == $past(frame_q[FRAME_W-2:0])));

endmodule

// File: rtl/dacfe_hold.sv
module dacfe_hold
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 12,
  localparam int FRAME_W = CODE_W + ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         loadn_s,
  input  logic [FRAME_W-1:0]           frame_i,
  output logic [NCH-1:0][CODE_W-1:0]   code_o
);

  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] data;
  logic [NCH-1:0]    wr_mask;

  assign addr    = frame_i[FRAME_W-1 -: ADDR_W];
  assign data    = frame_i[CODE_W-1:0];
  assign wr_mask = dst_mask(addr);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst)                          code_o[c] <= '0;
        else if (!loadn_s && wr_mask[c])  code_o[c] <= data;
      end
    end
  endgenerate

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    loadn_s |=> $stable(code_o));

  // R4
  both_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadn_s && !frame_i[FRAME_W-1]) |=>
      (code_o[CH_A] == $past(frame_i[CODE_W-1:0])) &&
      (code_o[CH_B] == $past(frame_i[CODE_W-1:0])));

  // R5
  a_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadn_s && frame_i[FRAME_W-1 -: 2] == 2'b10) |=>
      $stable(code_o[CH_B]) && (code_o[CH_A] == $past(frame_i[CODE_W-1:0])));

  // R6
  b_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadn_s && frame_i[FRAME_W-1 -: 2] == 2'b11) |=>
      $stable(code_o[CH_A]) && (code_o[CH_B] == $past(frame_i[CODE_W-1:0])));

endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
  import dacfe_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              csn_i,
  input  logic              loadn_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o
);

  localparam int FRAME_W = CODE_W + ADDR_W;
  localparam int PIN_W   = 4;
  // pin order in the synchronized bus: {loadn, csn, sdata, sclk}
  localparam logic [PIN_W-1:0] PIN_IDLE = 4'b1100;

  logic [PIN_W-1:0]          pins_s;
  logic                      shift_en;
  logic [FRAME_W-1:0]        frame;
  logic [NCH-1:0][CODE_W-1:0] codes;

  dacfe_sync #(
    .WIDTH   (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({loadn_i, csn_i, sdata_i, sclk_i}),
    .sync_o  (pins_s)
  );

  dacfe_shift #(
    .CODE_W (CODE_W),
    .ADDR_W (ADDR_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (pins_s[0]),
    .csn_s    (pins_s[2]),
    .sdata_s  (pins_s[1]),
    .shift_en (shift_en),
    .frame_o  (frame)
  );

  dacfe_hold #(
    .CODE_W (CODE_W)
  ) u_hold (
    .clk     (clk),
    .rst     (rst),
    .loadn_s (pins_s[3]),
    .frame_i (frame),
    .code_o  (codes)
  );

  assign code_a_o = codes[CH_A];
  assign code_b_o = codes[CH_B];

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (code_a_o == '0) && (code_b_o == '0));

endmodule

// File: tb/tb_dual_dac_frontend.sv
module tb_dual_dac_frontend;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, csn = 1'b1, loadn = 1'b1;
  logic [11:0] code_a, code_b;

  int checks = 0;
  int errors = 0;

  logic [13:0] m_frame = '0;
  logic [11:0] m_a = '0, m_b = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_frontend dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata),
    .csn_i(csn), .loadn_i(loadn), .code_a_o(code_a), .code_b_o(code_b)
  );

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model of the address-driven update while the strobe is low
  function automatic void model_update();
    if (!m_frame[13]) begin m_a = m_frame[11:0]; m_b = m_frame[11:0]; end
    else if (!m_frame[12]) m_a = m_frame[11:0];
    else m_b = m_frame[11:0];
  endfunction

  task automatic send_bit(input logic b);
    sdata = b;
    wait_clk(HALF_BIT);
    sclk = 1'b1;
    if (!csn) m_frame = {m_frame[12:0], b};
    wait_clk(HALF_BIT);
    sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n, input logic sel);
    csn = ~sel;
    wait_clk(HALF_BIT);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    wait_clk(HALF_BIT);
    csn = 1'b1;
    wait_clk(HALF_BIT);
  endtask

  task automatic pulse_load();
    loadn = 1'b0;
    wait_clk(6);
    model_update();
    loadn = 1'b1;
    wait_clk(6);
  endtask

  task automatic frame_load(input logic [1:0] addr, input logic [11:0] code);
    send_bits({18'd0, addr, code}, 14, 1'b1);
    pulse_load();
  endtask

  initial begin
    void'($urandom(32'd5150));
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    // R8 reset state
    check("R8 reset A", code_a, 12'h000);
    check("R8 reset B", code_b, 12'h000);

    // R9 straight-binary codes, R4 both channels
    frame_load(2'b00, 12'h800);
    check("R9/R4 mid A", code_a, 12'h800);
    check("R9/R4 mid B", code_b, 12'h800);
    frame_load(2'b01, 12'hFFF);
    check("R9/R4 full A", code_a, 12'hFFF);
    check("R9/R4 full B", code_b, 12'hFFF);
    // R5 channel A only
    frame_load(2'b10, 12'h000);
    check("R5 A zero", code_a, 12'h000);
    check("R5 B held", code_b, 12'hFFF);
    // R6 channel B only
    frame_load(2'b11, 12'h123);
    check("R6 B", code_b, 12'h123);
    check("R6 A held", code_a, 12'h000);

    // R3 outputs hold while strobe high during a new frame
    send_bits({18'd0, 2'b00, 12'hABC}, 14, 1'b1);
    check("R3 A held", code_a, 12'h000);
    check("R3 B held", code_b, 12'h123);
    pulse_load();
    check("R3 then load A", code_a, 12'hABC);

    // R2 edges while deselected are ignored
    send_bits({18'd0, 2'b00, 12'h555}, 14, 1'b0);
    pulse_load();
    check("R2 deselected A", code_a, 12'hABC);
    check("R2 deselected B", code_b, 12'hABC);

    // R1 extra leading bits: last 14 kept
    send_bits({15'd0, 3'b101, 2'b10, 12'h3C5}, 17, 1'b1);
    pulse_load();
    check("R1 overlong A", code_a, 12'h3C5);
    check("R1 overlong B", code_b, 12'hABC);

    // R7 transparency: strobe low while bits shift one at a time
    frame_load(2'b10, 12'h000);
    loadn = 1'b0;
    wait_clk(6);
    model_update();
    csn = 1'b0;
    wait_clk(HALF_BIT);
    begin
      logic [13:0] word;
      word = {2'b10, 12'hA5F};
      for (int i = 13; i >= 0; i--) begin
        send_bit(word[i]);
        wait_clk(5);
        model_update();
        check("R7 transparent A", code_a, m_a);
        check("R7 transparent B", code_b, m_b);
      end
    end
    csn = 1'b1;
    wait_clk(HALF_BIT);
    loadn = 1'b1;
    wait_clk(6);
    check("R7 final A", code_a, 12'hA5F);

    // R8 mid-run reset clears shift register too
    send_bits({18'd0, 2'b00, 12'h7E7}, 14, 1'b1);
    @(negedge clk); rst = 1'b1;
    wait_clk(3);
    rst = 1'b0;
    m_frame = '0; m_a = '0; m_b = '0;
    wait_clk(3);
    check("R8 mid reset A", code_a, 12'h000);
    pulse_load();
    check("R8 cleared frame B", code_b, 12'h000);

    // random frames, extra bits and deselected bursts (R1..R6)
    for (int it = 0; it < 40; it++) begin
      logic [1:0]  ad;
      logic [11:0] cd;
      int extra;
      ad = 2'($urandom % 4);
      cd = 12'($urandom % 4096);
      extra = int'($urandom % 3);
      if (extra != 0) send_bits(32'($urandom), extra, 1'b1);
      if ($urandom % 4 == 0) send_bits(32'($urandom), 6, 1'b0);
      send_bits({18'd0, ad, cd}, 14, 1'b1);
      if ($urandom % 4 == 0) send_bits(32'($urandom), 5, 1'b0);
      pulse_load();
      check("R1-frame rand A (R4 R5 R6)", code_a, m_a);
      check("R1-frame rand B (R4 R5 R6)", code_b, m_b);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule